// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Purge

This block holds a small, fully associative set of recent translations from virtual page numbers to physical frame numbers. Every entry records the process that owns it, so a context switch does not require flushing the cache. A translation counts only for the process that installed it.

A lookup presents a virtual page number, the current process and the access kind (read or write). The block answers one cycle later with a registered response. That response is either a hit, carrying the physical frame and a permission fault flag, or a miss that raises a refill request toward an external table walker. The walker installs the translation through the fill port. A single entry can stand for a normal 4 KB page or for a larger aligned superpage.

The operating system keeps the cache coherent through the purge port after it changes a mapping. It can drop one page of one process, every entry of one process, or the whole contents. On a multiprocessor, the same command is issued to the purge port of each processor's copy. Each purge takes effect in one cycle and is acknowledged with a one-cycle done pulse.

Top module: `ptag_tlb`

## Requirements
- R1: After reset every entry is invalid: rsp_valid and purge_done are low, and the first lookup misses with refill_req high.
- R2: A lookup hits only when an entry is valid, its page matches the presented page, and its stored process equals lk_pid. The same page under another process misses.
- R3: The response is registered. rsp_valid is high exactly one cycle after lk_valid. A hit returns the stored frame on rsp_frame. A miss returns rsp_hit=0, rsp_frame=0 and refill_req=1.
- R4: Permission field bit 0 allows reads and bit 1 allows writes (lk_write=1 means write). A hit whose access is not allowed gives rsp_hit=1 together with rsp_fault=1. A miss never faults.
- R5: The size field selects the page size. Code 0 is a 4 KB page. Code 1 ignores the low 9 page-number bits. Codes 2 and 3 ignore the low 18 bits. For a superpage hit, the ignored low bits of rsp_frame are taken from the looked-up page number.
- R6: A fill whose page falls inside a valid entry of the same process overwrites that entry instead of taking a new slot.
- R7: A fill that matches no entry goes to the lowest-numbered invalid entry. When all entries are valid it evicts the entry named by a round-robin pointer, which starts at entry 0 after reset and advances after each such eviction.
- R8: Purge mode 0 invalidates only the entries of process purge_pid that cover page purge_vpn.
- R9: Purge mode 1 invalidates every entry of process purge_pid and leaves other processes untouched.
- R10: Purge modes 2 and 3 invalidate all entries. Every purge raises purge_done for exactly the following cycle.
- R11: When a purge and a fill arrive in the same cycle, the purge is carried out and the fill is dropped.
- R12: A lookup made in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_pid | input | PID_W | Current process |
| lk_write | input | 1 | Access kind: 1 write, 0 read |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number of the new translation |
| fill_pid | input | PID_W | Owning process |
| fill_pfn | input | PFN_W | Physical frame |
| fill_size | input | 2 | Page size code |
| fill_perm | input | 2 | Bit 0 read allowed, bit 1 write allowed |
| purge_valid | input | 1 | Purge command |
| purge_mode | input | 2 | 0 page+process, 1 process, 2/3 all |
| purge_vpn | input | VPN_W | Page number for mode 0 |
| purge_pid | input | PID_W | Process for modes 0 and 1 |
| rsp_valid | output | 1 | Registered lookup response valid |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Hit, but access not permitted |
| rsp_frame | output | PFN_W | Physical frame of the hit |
| refill_req | output | 1 | Miss; walker should fetch the translation |
| purge_done | output | 1 | One-cycle acknowledge of a purge |

## Verification
The assertions check the timing contract on every cycle. Each lookup produces a response on the next cycle, and each purge produces its done pulse. A fault never appears without a hit, and nothing appears without a response. No hit can come from a lookup that follows a full purge. Whether the returned frame is correct, whether the superpage masks are right, whether a refill is deduplicated, and which entry the replacement picks all depend on the sequence of earlier fills and purges. These can only be shown by the bench's scenarios, which fill the cache, overflow it and purge it selectively.

// File: rtl/ptag_tlb.sv
module ptag_tlb #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int PID_W = 8,
  parameter int LVL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_write,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [1:0]       fill_size,
  input  logic [1:0]       fill_perm,
  input  logic             purge_valid,
  input  logic [1:0]       purge_mode,
  input  logic [VPN_W-1:0] purge_vpn,
  input  logic [PID_W-1:0] purge_pid,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PFN_W-1:0] rsp_frame,
  output logic             refill_req,
  output logic             purge_done
);
  localparam int IDX_W = $clog2(N);
  localparam int MW    = (VPN_W > PFN_W) ? VPN_W : PFN_W;

  function automatic logic [MW-1:0] sz_mask(input logic [1:0] s);
    logic [MW-1:0] m;
    m = '0;
    for (int b = 0; b < MW; b++)
      if ((s == 2'd1 && b < LVL_W) || (s[1] && b < 2*LVL_W)) m[b] = 1'b1;
    return m;
  endfunction

  logic [N-1:0]       e_v;
  logic [VPN_W-1:0]   e_vpn  [N];
  logic [PFN_W-1:0]   e_pfn  [N];
  logic [PID_W-1:0]   e_pid  [N];
  logic [1:0]         e_sz   [N];
  logic [1:0]         e_perm [N];
  logic [IDX_W-1:0]   rr;

  logic [N-1:0] lk_m, fill_m, purge_m;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [VPN_W-1:0] keep;
    assign keep = ~sz_mask(e_sz[i])[VPN_W-1:0];
    assign lk_m[i]   = e_v[i] && e_pid[i] == lk_pid &&
                       ((e_vpn[i] ^ lk_vpn) & keep) == '0;
    assign fill_m[i] = e_v[i] && e_pid[i] == fill_pid &&
                       ((e_vpn[i] ^ fill_vpn) & keep) == '0;
    assign purge_m[i] = purge_mode[1] ||
                        (e_v[i] && e_pid[i] == purge_pid &&
                         (purge_mode[0] || ((e_vpn[i] ^ purge_vpn) & keep) == '0));
  end

  logic [IDX_W-1:0] hit_idx, cov_idx, inv_idx, victim;
  always_comb begin
    hit_idx = '0;
    cov_idx = '0;
    inv_idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (lk_m[i])   hit_idx = IDX_W'(i);
      if (fill_m[i]) cov_idx = IDX_W'(i);
      if (!e_v[i])   inv_idx = IDX_W'(i);
    end
    if (|fill_m)      victim = cov_idx;
    else if (~&e_v)   victim = inv_idx;
    else              victim = rr;
  end

  logic [MW-1:0]    hmask;
  logic [MW-1:0]    vpn_x;
  logic [PFN_W-1:0] hit_frame;
  logic             perm_ok;
  assign hmask     = sz_mask(e_sz[hit_idx]);
  assign vpn_x     = MW'(lk_vpn);
  assign hit_frame = (e_pfn[hit_idx] & ~hmask[PFN_W-1:0]) | (vpn_x[PFN_W-1:0] & hmask[PFN_W-1:0]);
  assign perm_ok   = lk_write ? e_perm[hit_idx][1] : e_perm[hit_idx][0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_frame  <= '0;
      purge_done <= 1'b0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_valid && |lk_m;
      rsp_fault  <= lk_valid && |lk_m && !perm_ok;
      rsp_frame  <= (lk_valid && |lk_m) ? hit_frame : '0;
      purge_done <= purge_valid;
    end
  end

  assign refill_req = rsp_valid && !rsp_hit;

  logic [MW-1:0] fmask;
  assign fmask = sz_mask(fill_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v <= '0;
      rr  <= '0;
      for (int i = 0; i < N; i++) begin
        e_vpn[i]  <= '0;
        e_pfn[i]  <= '0;
        e_pid[i]  <= '0;
        e_sz[i]   <= '0;
        e_perm[i] <= '0;
      end
    end else if (purge_valid) begin
      e_v <= e_v & ~purge_m;
    end else if (fill_valid) begin
      e_v[victim]    <= 1'b1;
      e_vpn[victim]  <= fill_vpn & ~fmask[VPN_W-1:0];
      e_pfn[victim]  <= fill_pfn & ~fmask[PFN_W-1:0];
      e_pid[victim]  <= fill_pid;
      e_sz[victim]   <= fill_size;
      e_perm[victim] <= fill_perm;
      if (!(|fill_m) && &e_v)
        rr <= (rr == IDX_W'(N-1)) ? '0 : rr + 1'b1;
    end
  end
endmodule

module ptag_tlb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_valid,
  input logic       purge_valid,
  input logic [1:0] purge_mode,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic       rsp_fault,
  input logic       refill_req,
  input logic       purge_done
);
  AST_RSP_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R3
  AST_NO_RSP_WITHOUT_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R3
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit && !refill_req); // R3
  AST_DONE_AFTER_PURGE: assert property (@(posedge clk) disable iff (!rst_n)
    purge_valid |=> purge_done); // R10
  AST_DONE_ONLY_AFTER_PURGE: assert property (@(posedge clk) disable iff (!rst_n)
    !purge_valid |=> !purge_done); // R10
  AST_EMPTY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(purge_valid && purge_mode[1], 2)) |-> !rsp_hit); // R10
endmodule

bind ptag_tlb ptag_tlb_chk chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .purge_valid(purge_valid),
  .purge_mode(purge_mode), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_fault(rsp_fault), .refill_req(refill_req), .purge_done(purge_done)
);

// File: tb/ptag_tlb_tb_top.sv
module ptag_tlb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        lk_valid = 0, lk_write = 0, fill_valid = 0, purge_valid = 0;
  logic [19:0] lk_vpn = 0, fill_vpn = 0, purge_vpn = 0, fill_pfn = 0;
  logic [7:0]  lk_pid = 0, fill_pid = 0, purge_pid = 0;
  logic [1:0]  fill_size = 0, fill_perm = 0, purge_mode = 0;
  logic        rsp_valid, rsp_hit, rsp_fault, refill_req, purge_done;
  logic [19:0] rsp_frame;

  ptag_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .lk_write(lk_write), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_pfn(fill_pfn), .fill_size(fill_size), .fill_perm(fill_perm),
    .purge_valid(purge_valid), .purge_mode(purge_mode), .purge_vpn(purge_vpn),
    .purge_pid(purge_pid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_frame(rsp_frame), .refill_req(refill_req), .purge_done(purge_done)
  );

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] p, input logic [19:0] f,
                      input logic [1:0] s, input logic [1:0] pm);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_pid = p; fill_pfn = f; fill_size = s; fill_perm = pm;
    @(negedge clk);
    fill_valid = 0;
  endtask

  // result packed {valid, hit, fault, refill, frame}
  task automatic look(input logic [19:0] v, input logic [7:0] p, input logic w,
                      output logic [23:0] r);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_pid = p; lk_write = w;
    @(negedge clk);
    r = {rsp_valid, rsp_hit, rsp_fault, refill_req, rsp_frame};
    lk_valid = 0;
  endtask

  task automatic purge(input logic [1:0] m, input logic [19:0] v, input logic [7:0] p,
                       input string req);
    @(negedge clk);
    purge_valid = 1; purge_mode = m; purge_vpn = v; purge_pid = p;
    @(negedge clk);
    purge_valid = 0;
    chk({req, " done pulse"}, 32'(purge_done), 1);
    @(negedge clk);
    chk({req, " done drops"}, 32'(purge_done), 0);
  endtask

  function automatic logic [23:0] hitv(input logic [19:0] f, input logic flt);
    return {1'b1, 1'b1, flt, 1'b0, f};
  endfunction
  localparam logic [23:0] MISS = {4'b1001, 20'h0};

  // {vpn, pid, write, expected}
  localparam int NV = 13;
  localparam logic [52:0] VEC [NV] = '{
    {20'h12345, 8'd1, 1'b0, 24'hC0ABCD},  // R2 hit
    {20'h12345, 8'd2, 1'b0, MISS},        // R2 other process
    {20'h12344, 8'd1, 1'b0, MISS},        // R2 other page
    {20'h00400, 8'd2, 1'b0, 24'hC00008},  // R3 frame
    {20'h00400, 8'd2, 1'b1, 24'hE00008},  // R4 write to read-only
    {20'h12345, 8'd1, 1'b1, 24'hC0ABCD},  // R4 write allowed
    {20'h203FF, 8'd1, 1'b0, 24'hC555FF},  // R5 2MB low bits
    {20'h20400, 8'd1, 1'b0, MISS},        // R5 outside 2MB
    {20'h20200, 8'd1, 1'b1, 24'hC55400},  // R5 2MB base
    {20'hBFFFF, 8'd3, 1'b0, 24'hCFFFFF},  // R5 1GB low bits
    {20'hBFFFF, 8'd3, 1'b1, 24'hEFFFFF},  // R4 fault on superpage
    {20'hC0000, 8'd3, 1'b0, MISS},        // R5 outside 1GB
    {20'h80001, 8'd1, 1'b0, MISS}         // R2 process on superpage
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R1: watchdog expired, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [23:0] r;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 purge_done", 32'(purge_done), 0);
    look(20'h12345, 8'd1, 0, r); chk("R1 first lookup misses", 32'(r), 32'(MISS));

    fill(20'h12345, 8'd1, 20'h0ABCD, 2'd0, 2'b11);
    fill(20'h00400, 8'd2, 20'h00008, 2'd0, 2'b01);
    fill(20'h20200, 8'd1, 20'h55400, 2'd1, 2'b11);
    fill(20'h80000, 8'd3, 20'hC0000, 2'd2, 2'b01);
    for (int i = 0; i < NV; i++) begin
      look(VEC[i][52:33], VEC[i][32:25], VEC[i][24], r);
      chk($sformatf("R2/R3/R4/R5 vector %0d", i), 32'(r), 32'(VEC[i][23:0]));
    end

    // R7 replacement
    purge(2'd2, 0, 0, "R10");
    look(20'h12345, 8'd1, 0, r); chk("R10 purge all empties", 32'(r), 32'(MISS));
    for (int i = 0; i < 16; i++) fill(20'h100 + 20'(i), 8'd5, 20'h700 + 20'(i), 2'd0, 2'b01);
    fill(20'h200, 8'd5, 20'h800, 2'd0, 2'b01);
    fill(20'h201, 8'd5, 20'h801, 2'd0, 2'b01);
    look(20'h100, 8'd5, 0, r); chk("R7 entry 0 evicted first", 32'(r), 32'(MISS));
    look(20'h101, 8'd5, 0, r); chk("R7 entry 1 evicted next", 32'(r), 32'(MISS));
    look(20'h102, 8'd5, 0, r); chk("R7 entry 2 kept", 32'(r), 32'(hitv(20'h702, 0)));
    look(20'h201, 8'd5, 0, r); chk("R7 new entry", 32'(r), 32'(hitv(20'h801, 0)));
    purge(2'd0, 20'h105, 8'd5, "R8");
    fill(20'h202, 8'd5, 20'h802, 2'd0, 2'b01);
    look(20'h102, 8'd5, 0, r); chk("R7 invalid slot preferred", 32'(r), 32'(hitv(20'h702, 0)));
    look(20'h202, 8'd5, 0, r); chk("R7 fill into freed slot", 32'(r), 32'(hitv(20'h802, 0)));
    look(20'h105, 8'd5, 0, r); chk("R8 purged page", 32'(r), 32'(MISS));

    // R6 dedupe
    purge(2'd3, 0, 0, "R10");
    look(20'h102, 8'd5, 0, r); chk("R10 mode 3 empties", 32'(r), 32'(MISS));
    fill(20'h400, 8'd7, 20'h1, 2'd0, 2'b01);
    fill(20'h400, 8'd7, 20'h2, 2'd0, 2'b01);
    for (int i = 1; i < 16; i++) fill(20'h400 + 20'(i), 8'd7, 20'h10 + 20'(i), 2'd0, 2'b01);
    look(20'h400, 8'd7, 0, r); chk("R6 overwritten frame", 32'(r), 32'(hitv(20'h2, 0)));
    for (int i = 1; i < 16; i++) begin
      look(20'h400 + 20'(i), 8'd7, 0, r);
      chk("R6 no duplicate slot used", 32'(r), 32'(hitv(20'h10 + 20'(i), 0)));
    end

    // R8 / R9
    purge(2'd2, 0, 0, "R10");
    fill(20'h500, 8'd8, 20'hA0, 2'd0, 2'b01);
    fill(20'h500, 8'd9, 20'hA1, 2'd0, 2'b01);
    fill(20'h501, 8'd8, 20'hA2, 2'd0, 2'b01);
    fill(20'h600, 8'd9, 20'hA3, 2'd0, 2'b01);
    purge(2'd0, 20'h500, 8'd8, "R8");
    look(20'h500, 8'd8, 0, r); chk("R8 target gone", 32'(r), 32'(MISS));
    look(20'h500, 8'd9, 0, r); chk("R8 other process kept", 32'(r), 32'(hitv(20'hA1, 0)));
    look(20'h501, 8'd8, 0, r); chk("R8 other page kept", 32'(r), 32'(hitv(20'hA2, 0)));
    purge(2'd1, 0, 8'd9, "R9");
    look(20'h500, 8'd9, 0, r); chk("R9 process entry gone", 32'(r), 32'(MISS));
    look(20'h600, 8'd9, 0, r); chk("R9 process entry gone", 32'(r), 32'(MISS));
    look(20'h501, 8'd8, 0, r); chk("R9 other process kept", 32'(r), 32'(hitv(20'hA2, 0)));

    // R11 purge beats fill
    @(negedge clk);
    purge_valid = 1; purge_mode = 2'd2;
    fill_valid = 1; fill_vpn = 20'h900; fill_pid = 8'd4; fill_pfn = 20'hB0;
    fill_size = 0; fill_perm = 2'b01;
    @(negedge clk);
    purge_valid = 0; fill_valid = 0;
    chk("R11 done pulse", 32'(purge_done), 1);
    look(20'h900, 8'd4, 0, r); chk("R11 fill dropped", 32'(r), 32'(MISS));
    look(20'h501, 8'd8, 0, r); chk("R11 purge applied", 32'(r), 32'(MISS));

    // R12 lookup concurrent with fill
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'hA00; fill_pid = 8'd4; fill_pfn = 20'hC0;
    fill_size = 0; fill_perm = 2'b11;
    lk_valid = 1; lk_vpn = 20'hA00; lk_pid = 8'd4; lk_write = 0;
    @(negedge clk);
    fill_valid = 0; lk_valid = 0;
    chk("R12 same-cycle lookup misses", 32'({rsp_valid, rsp_hit, rsp_fault, refill_req, rsp_frame}), 32'(MISS));
    look(20'hA00, 8'd4, 1, r); chk("R12 later lookup hits", 32'(r), 32'(hitv(20'hC0, 0)));
    @(negedge clk);
    chk("R3 rsp_valid falls", 32'(rsp_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule